// File: doc/BRIEF.md
# Load-Use Stall Controller

This block watches the boundary between the decode and execute stages of a five-stage in-order pipeline. It raises a one-cycle stall when the instruction sitting in decode needs a register whose value is still being fetched from memory by a load that is currently in execute. Such a value only exists once the memory stage completes, so forwarding cannot deliver it to an instruction that enters execute immediately behind the load. Every other read-after-write case is left to the forwarding network.

While stalled, the program counter and the fetch/decode register keep their contents, so the dependent instruction waits in decode for one cycle. The load keeps moving, and the execute-stage control word captured behind it becomes a no-op: its register-write and memory-write bits are cleared and all other bits pass through unchanged. That control word is held in a register inside this block. The store-data operand of a store is exempt, because that value can be forwarded later, into the memory stage. A branch flush request wins over the stall, so an instruction on the wrong path is squashed and never held.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: A hazard exists when ex_mem_rd is 1, ex_dst is nonzero, and either id_rs equals ex_dst with id_src_used[0] set, or id_rt equals ex_dst with id_src_used[1] set. With no flush, a hazard drives pc_we=0, ifid_we=0 and idex_bubble=1 in the same cycle.
- R2: When ex_mem_rd is 0 and there is no flush, pc_we=1, ifid_we=1 and idex_bubble=0, whatever the register fields hold.
- R3: A load whose destination is register 0 never causes a stall.
- R4: A source field whose use bit in id_src_used is 0 never causes a stall, even when it matches ex_dst.
- R5: When id_is_store is 1, a match on id_rt (the store-data operand) causes no stall. A match on id_rs (the base address) still stalls under R1.
- R6: When flush_req is 1, pc_we=1, ifid_we=1 and idex_bubble=1, whatever the hazard inputs hold.
- R7: At each rising clock edge, idex_ctrl_q captures id_ctrl. When idex_bubble was 1, bit 0 (register write) and bit 1 (memory write) are captured as 0 and every other bit is captured unchanged.
- R8: A synchronous active-high rst clears idex_ctrl_q to all zeros at the next rising edge.
- R9: pc_we and ifid_we always hold the same value, and pc_we=0 never occurs without idex_bubble=1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_mem_rd | input | 1 | Instruction in execute reads memory (a load) |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| id_rs | input | REG_W | First source field of the instruction in decode |
| id_rt | input | REG_W | Second source field of the instruction in decode |
| id_src_used | input | 2 | Bit 0: id_rs is read; bit 1: id_rt is read |
| id_is_store | input | 1 | Instruction in decode is a store (id_rt is its data operand) |
| flush_req | input | 1 | Taken-branch flush request |
| id_ctrl | input | CTRL_W | Control word of the decode instruction headed for execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Turns the captured execute-stage control word into a no-op |
| idex_ctrl_q | output | CTRL_W | Registered execute-stage control word |

## Verification
A wrong comparison or a wrong gating term shows up on pc_we, ifid_we and idex_bubble in the same cycle as the input pattern that triggers it, because the decision logic holds no state. A fault in the bubble gate or the control register shows up on idex_ctrl_q one edge later, as a surviving write bit or a corrupted pass-through bit. The bench therefore sweeps every combination of load flag, destination, both sources, use bits, store flag and flush on a narrow register index. For each combination it checks the enables in-cycle and the captured control word after the next edge.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Number of decode-stage source operands examined.
  localparam int NUM_SRC = 2;
  // Source slot that carries store data (exempt from stalling on stores).
  localparam int STORE_DATA_SLOT = 1;

  // Bit positions in the execute-stage control word cleared by a bubble.
  localparam int CTRL_REG_WR_BIT = 0;
  localparam int CTRL_MEM_WR_BIT = 1;

  // Front-end action chosen for the current cycle.
  typedef enum logic [1:0] {
    ACT_RUN    = 2'd0,
    ACT_STALL  = 2'd1,
    ACT_SQUASH = 2'd2
  } fe_action_t;

endpackage

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
  parameter int REG_W = 5
) (
  input  logic             ld_valid,
  input  logic [REG_W-1:0] ld_dst,
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  output logic             hit
);

  logic dst_nonzero;

  always_comb begin
    dst_nonzero = |ld_dst;
    hit = ld_valid && dst_nonzero && src_used && (src == ld_dst);
  end

endmodule

// File: rtl/ldu_detect.sv
module ldu_detect
  import ldu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_mem_rd,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic [REG_W-1:0]   src_a,
  input  logic [REG_W-1:0]   src_b,
  input  logic [NUM_SRC-1:0] src_used,
  input  logic               is_store,
  output logic               hazard
);

  logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
  logic [NUM_SRC-1:0]            eff_used;
  logic [NUM_SRC-1:0]            slot_hit;

  always_comb begin
    src_vec[0] = src_a;
    src_vec[1] = src_b;
  end

  // Each slot gets its own comparator; the store-data slot is masked on stores.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    if (s == STORE_DATA_SLOT) begin : g_store_masked
      always_comb eff_used[s] = src_used[s] && !is_store;
    end else begin : g_plain
      always_comb eff_used[s] = src_used[s];
    end

    ldu_src_match #(.REG_W(REG_W)) u_match (
      .ld_valid (ex_mem_rd),
      .ld_dst   (ex_dst),
      .src      (src_vec[s]),
      .src_used (eff_used[s]),
      .hit      (slot_hit[s])
    );
  end

  always_comb hazard = |slot_hit;

  AST_NO_HAZ_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ex_mem_rd |-> !hazard);  // R2

  AST_ZERO_DST_NO_HAZ: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == '0) |-> !hazard);  // R3

  AST_UNUSED_NO_HAZ: assert property (@(posedge clk) disable iff (rst)
    (src_used == '0) |-> !hazard);  // R4

  AST_STORE_DATA_EXEMPT: assert property (@(posedge clk) disable iff (rst)
    (is_store && !src_used[0]) |-> !hazard);  // R5

endmodule

// File: rtl/ldu_arbiter.sv
module ldu_arbiter
  import ldu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hazard,
  input  logic flush_req,
  output logic pc_we,
  output logic ifid_we,
  output logic bubble
);

  fe_action_t act;

  // Flush has priority so a wrong-path instruction is squashed, never held.
  always_comb begin
    if (flush_req)   act = ACT_SQUASH;
    else if (hazard) act = ACT_STALL;
    else             act = ACT_RUN;
  end

  always_comb begin
    pc_we   = 1'b1;
    ifid_we = 1'b1;
    bubble  = 1'b0;
    unique case (act)
      ACT_STALL: begin
        pc_we   = 1'b0;
        ifid_we = 1'b0;
        bubble  = 1'b1;
      end
      ACT_SQUASH: bubble = 1'b1;
      default: ;
    endcase
  end

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (pc_we && ifid_we && bubble));  // R6

  AST_HAZARD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (hazard && !flush_req) |-> (!pc_we && !ifid_we && bubble));  // R1

  AST_FREEZE_HAS_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !pc_we |-> (bubble && !ifid_we));  // R9

endmodule

// File: rtl/ldu_idex_ctrl.sv
module ldu_idex_ctrl
  import ldu_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bubble,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_q
);

  localparam logic [CTRL_W-1:0] KILL_MASK =
    CTRL_W'((1 << CTRL_REG_WR_BIT) | (1 << CTRL_MEM_WR_BIT));

  logic [CTRL_W-1:0] ctrl_d;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (KILL_MASK[b]) begin : g_kill
      always_comb ctrl_d[b] = ctrl_in[b] && !bubble;
    end else begin : g_pass
      always_comb ctrl_d[b] = ctrl_in[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  AST_BUBBLE_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (!ctrl_q[CTRL_REG_WR_BIT] && !ctrl_q[CTRL_MEM_WR_BIT]));  // R7

  AST_PASS_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ctrl_q & ~KILL_MASK) == ($past(ctrl_in) & ~KILL_MASK)));  // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0));  // R8

endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
  import ldu_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_mem_rd,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [1:0]        id_src_used,
  input  logic              id_is_store,
  input  logic              flush_req,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic [CTRL_W-1:0] idex_ctrl_q
);

  logic hazard;

  ldu_detect #(.REG_W(REG_W)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .ex_mem_rd (ex_mem_rd),
    .ex_dst    (ex_dst),
    .src_a     (id_rs),
    .src_b     (id_rt),
    .src_used  (id_src_used),
    .is_store  (id_is_store),
    .hazard    (hazard)
  );

  ldu_arbiter u_arb (
    .clk       (clk),
    .rst       (rst),
    .hazard    (hazard),
    .flush_req (flush_req),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .bubble    (idex_bubble)
  );

  ldu_idex_ctrl #(.CTRL_W(CTRL_W)) u_idex (
    .clk     (clk),
    .rst     (rst),
    .bubble  (idex_bubble),
    .ctrl_in (id_ctrl),
    .ctrl_q  (idex_ctrl_q)
  );

endmodule

// File: tb/tb_ldu_stall_ctrl.sv
module tb_ldu_stall_ctrl;

  localparam int REG_W  = 3;
  localparam int CTRL_W = 8;
  localparam int NREG   = 1 << REG_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              ex_mem_rd;
  logic [REG_W-1:0]  ex_dst;
  logic [REG_W-1:0]  id_rs;
  logic [REG_W-1:0]  id_rt;
  logic [1:0]        id_src_used;
  logic              id_is_store;
  logic              flush_req;
  logic [CTRL_W-1:0] id_ctrl;
  logic              pc_we;
  logic              ifid_we;
  logic              idex_bubble;
  logic [CTRL_W-1:0] idex_ctrl_q;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ldu_stall_ctrl #(.REG_W(REG_W), .CTRL_W(CTRL_W)) dut (
    .clk         (clk),
    .rst         (rst),
    .ex_mem_rd   (ex_mem_rd),
    .ex_dst      (ex_dst),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_src_used (id_src_used),
    .id_is_store (id_is_store),
    .flush_req   (flush_req),
    .id_ctrl     (id_ctrl),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble),
    .idex_ctrl_q (idex_ctrl_q)
  );

  task automatic check_vec(string req, logic [CTRL_W-1:0] act, logic [CTRL_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : main
    logic [CTRL_W-1:0] exp_q;
    bit                have_prev;
    rst = 1'b1; ex_mem_rd = 0; ex_dst = 0; id_rs = 0; id_rt = 0;
    id_src_used = 0; id_is_store = 0; flush_req = 0; id_ctrl = 8'hFF;
    repeat (3) @(negedge clk);
    // R8: reset state of the control register
    check_vec("R8", idex_ctrl_q, '0);
    rst = 1'b0;
    // R2: idle enables with no load
    #1 check_vec("R2", {5'b0, pc_we, ifid_we, idex_bubble}, 8'b110);
    have_prev = 1'b0;
    exp_q = '0;
    for (int fl = 0; fl < 2; fl++)
    for (int st = 0; st < 2; st++)
    for (int ld = 0; ld < 2; ld++)
    for (int us = 0; us < 4; us++)
    for (int d = 0; d < NREG; d++)
    for (int a = 0; a < NREG; a++)
    for (int b = 0; b < NREG; b++) begin
      logic hz_a, hz_b, stall, exp_pc, exp_bub;
      logic [CTRL_W-1:0] c;
      string req;
      @(negedge clk);
      if (have_prev) check_vec("R7", idex_ctrl_q, exp_q);
      c = CTRL_W'((a * 37) ^ (b * 11) ^ (d * 73) ^ (us * 5) ^ (st << 7) ^ (fl << 6));
      ex_mem_rd = ld[0]; ex_dst = d[REG_W-1:0]; id_rs = a[REG_W-1:0];
      id_rt = b[REG_W-1:0]; id_src_used = us[1:0]; id_is_store = st[0];
      flush_req = fl[0]; id_ctrl = c;
      hz_a  = (ld == 1) && (d != 0) && us[0] && (a == d);
      hz_b  = (ld == 1) && (d != 0) && us[1] && (st == 0) && (b == d);
      stall = (hz_a || hz_b) && (fl == 0);
      exp_pc  = !stall;
      exp_bub = stall || (fl == 1);
      if (fl == 1)                                   req = "R6";
      else if (ld == 0)                              req = "R2";
      else if (d == 0)                               req = "R3";
      else if (st == 1 && us[1] && b == d && !hz_a)  req = "R5";
      else if ((a == d && !us[0]) || (b == d && !us[1])) req = "R4";
      else                                           req = "R1/R9";
      #1 check_vec(req, {5'b0, pc_we, ifid_we, idex_bubble},
                   {5'b0, exp_pc, exp_pc, exp_bub});
      exp_q = exp_bub ? (c & ~CTRL_W'(3)) : c;
      have_prev = 1'b1;
    end
    @(negedge clk);
    check_vec("R7", idex_ctrl_q, exp_q);
    // R8: synchronous reset clears a nonzero register
    rst = 1'b1;
    @(negedge clk);
    check_vec("R8", idex_ctrl_q, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule